// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Filter

This block is an eight-tap finite impulse response filter for unsigned 8-bit samples. It uses a single multiply-accumulate unit for all taps. When a sample is accepted, it enters a shifting history store. A small controller then walks one tap index across the coefficient table and the history on eight successive clocks. The product for each tap goes into one accumulator, and the finished sum is registered on a 19-bit output with a one-cycle valid pulse.

The coefficients are a synthesis parameter, so a different filter needs only a new parameter value. The filter accepts one sample per eight clocks. If the next sample is offered during the last compute cycle of the current window, the filter streams at its full rate with no idle gap. Samples offered while a window is still in its earlier cycles are dropped.

Top module: `serial_mac_fir`

## Requirements
- R1: Samples and coefficients are 8-bit unsigned and the result is 19-bit unsigned. The result never wraps: with every sample and every coefficient at 255 the result is 520200.
- R2: An accepted sample becomes history entry 0, each older entry moves up one place, and entry 7 is dropped. The result is the sum over k = 0..7 of h[k]*x[n-k], where h[k] is bits [8k+7:8k] of parameter `COEFFS`.
- R3: Each window starts from an empty accumulator. The product for tap 0 loads the accumulator, so no part of an earlier window carries into the next result.
- R4: If a sample is accepted at clock edge t, `resultValid` is high for exactly the one cycle after edge t+8, with the matching `result`. In every other cycle it is low.
- R5: A sample is accepted when `sampleValid` is high while the filter is idle or in the last compute cycle of a window. With `sampleValid` held high, one sample is taken every 8 clocks.
- R6: `sampleValid` in the first seven compute cycles of a window is ignored. The history and later results are unchanged by such a sample.
- R7: `result` holds its last value in every cycle where `resultValid` is low.
- R8: Synchronous active-high `rst` clears the history, accumulator, tap counter, `result` and `resultValid`. An operation cut short by reset produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleIn | input | 8 | Unsigned input sample |
| sampleValid | input | 1 | Sample offered this cycle |
| result | output | 19 | Filter output, held between pulses |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench holds `sampleValid` high with junk values between the accept slots. A design that accepted every strobe, or that missed the last-cycle slot, would shift the wrong samples into the history and show mismatches or lost pulses. A second instance with all coefficients at 255 is fed runs of 255 to reach the 19-bit peak, where a narrow sum would wrap. Outputs that follow nonzero history, and a reset applied mid-window, show whether the accumulator fails to reload on tap 0 or whether stale history leaks into the first result after reset.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  localparam int TAP_CNT   = 8;
  localparam int TAP_IDX_W = $clog2(TAP_CNT);

  typedef struct packed {
    logic                 shiftIn;  // push a new sample into the history
    logic                 accEn;    // accumulate this cycle's product
    logic                 accClr;   // first tap: load instead of add
    logic                 finish;   // last tap: register the result
    logic [TAP_IDX_W-1:0] tap;      // shared coefficient/history index
  } ctrlStrobes_t;
endpackage

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleValid,
  output ctrlStrobes_t strobes
);
  localparam logic [TAP_IDX_W-1:0] LAST_TAP = TAP_IDX_W'(TAP_CNT - 1);

  logic                 busy;
  logic [TAP_IDX_W-1:0] cnt;
  logic                 ready;
  logic                 accept;

  assign ready  = !busy || (cnt == LAST_TAP);
  assign accept = sampleValid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST_TAP) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shiftIn = accept;
    strobes.accEn   = busy;
    strobes.accClr  = busy && (cnt == '0);
    strobes.finish  = busy && (cnt == LAST_TAP);
    strobes.tap     = cnt;
  end

  // R3: taps advance by one each clock inside a window, and strobes offered
  // mid-window do not restart it (R6)
  assert_tap_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST_TAP) |=> (busy && cnt == TAP_IDX_W'($past(cnt) + 1'b1)));

  // R6: a strobe before the last tap leaves the window running
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST_TAP && sampleValid) |=> (cnt != '0));

  // R5: a window only opens right after an accepted sample
  assert_clear_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.accClr |-> $past(sampleValid));
endmodule

// File: rtl/sfir_history.sv
module sfir_history
  import sfir_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shiftEn,
  input  logic [SAMPLE_W-1:0]  sampleIn,
  input  logic [TAP_IDX_W-1:0] tapSel,
  output logic [SAMPLE_W-1:0]  tapSample
);
  logic [SAMPLE_W-1:0] hist [TAP_CNT];

  always_ff @(posedge clk) begin
    if (rst) hist[0] <= '0;
    else if (shiftEn) hist[0] <= sampleIn;
  end

  for (genvar k = 1; k < TAP_CNT; k++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst) hist[k] <= '0;
      else if (shiftEn) hist[k] <= hist[k-1];
    end

    // R2: every stored sample moves up one place on a push
    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
      shiftEn |=> (hist[k] == $past(hist[k-1])));
  end

  assign tapSample = hist[tapSel];

  // R2: the newest sample lands in entry 0
  assert_newest_R2: assert property (@(posedge clk) disable iff (rst)
    shiftEn |=> (hist[0] == $past(sampleIn)));
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac
  import sfir_pkg::*;
#(
  parameter int                        SAMPLE_W = 8,
  parameter int                        COEF_W   = 8,
  parameter int                        ACC_W    = 19,
  parameter logic [TAP_CNT*COEF_W-1:0] COEFFS   = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] tapSample,
  output logic [ACC_W-1:0]    result,
  output logic                resultValid
);
  logic [COEF_W-1:0] coef;
  logic [ACC_W-1:0]  prod;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sumNext;
  logic [ACC_W:0]    sumWide;

  assign coef    = COEFFS[strobes.tap*COEF_W +: COEF_W];
  assign prod    = ACC_W'(coef) * ACC_W'(tapSample);
  assign sumNext = strobes.accClr ? prod : (acc + prod);
  assign sumWide = {1'b0, acc} + {1'b0, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strobes.accEn) acc <= sumNext;
      if (strobes.finish) result <= sumNext;
      resultValid <= strobes.finish;
    end
  end

  // R1: the running sum never exceeds the result width
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    (strobes.accEn && !strobes.accClr) |-> !sumWide[ACC_W]);

  // R4: a result pulse lasts one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  // R7: the output is held between pulses
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> $stable(result));
endmodule

// File: rtl/serial_mac_fir.sv
module serial_mac_fir
  import sfir_pkg::*;
#(
  parameter int                        SAMPLE_W = 8,
  parameter int                        COEF_W   = 8,
  parameter logic [TAP_CNT*COEF_W-1:0] COEFFS   = 64'hFF09_4080_01FA_1103,
  localparam int                       ACC_W    = SAMPLE_W + COEF_W + TAP_IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  output logic [ACC_W-1:0]    result,
  output logic                resultValid
);
  ctrlStrobes_t        strobes;
  logic [SAMPLE_W-1:0] tapSample;

  sfir_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .strobes     (strobes)
  );

  sfir_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shiftEn   (strobes.shiftIn),
    .sampleIn  (sampleIn),
    .tapSel    (strobes.tap),
    .tapSample (tapSample)
  );

  sfir_mac #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .COEFFS   (COEFFS)
  ) u_mac (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .tapSample   (tapSample),
    .result      (result),
    .resultValid (resultValid)
  );
endmodule

// File: tb/tb_serial_mac_fir.sv
module tb_serial_mac_fir;
  localparam logic [63:0] COEF_A   = 64'h2C07_90FF_0301_A05B;
  localparam logic [63:0] COEF_MAX = {8{8'hFF}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [18:0] resultA, resultB;
  logic        validA, validB;

  always #2 clk = ~clk;  // 250 MHz

  serial_mac_fir #(.COEFFS(COEF_A)) dut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .result(resultA), .resultValid(validA));

  serial_mac_fir #(.COEFFS(COEF_MAX)) dutMax (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .result(resultB), .resultValid(validB));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int edgeIdx = 0;
  int lastAcc = -100;
  int dueEdge = -1;
  int pendA = 0, pendB = 0;
  int lastA = 0, lastB = 0;
  int hist [8];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, edgeIdx);
    end
  endtask

  function automatic int conv(input logic [63:0] c);
    int s = 0;
    for (int k = 0; k < 8; k++) s += int'(c[k*8 +: 8]) * hist[k];
    return s;
  endfunction

  function automatic bit readyNext();
    return (edgeIdx + 1 - lastAcc) >= 8;
  endfunction

  // drive one cycle, model the edge, check outputs at the following negedge
  task automatic step(input logic v, input logic [7:0] x, input string tag);
    bit expectNow;
    int nowA, nowB;
    sampleValid = v;
    sampleIn    = x;
    @(posedge clk);
    edgeIdx++;
    expectNow = (dueEdge == edgeIdx);
    nowA = pendA;
    nowB = pendB;
    if (v && (edgeIdx - lastAcc) >= 8) begin
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'(x);
      lastAcc = edgeIdx;
      dueEdge = edgeIdx + 8;
      pendA = conv(COEF_A);
      pendB = conv(COEF_MAX);
    end
    @(negedge clk);
    chk("R4 valid timing A", int'(validA), int'(expectNow));
    chk("R4 valid timing B", int'(validB), int'(expectNow));
    if (expectNow) begin
      chk({tag, " result A"}, int'(resultA), nowA);
      chk({tag, " result B"}, int'(resultB), nowB);
      lastA = nowA;
      lastB = nowB;
    end else begin
      chk("R7 hold A", int'(resultA), lastA);
      chk("R7 hold B", int'(resultB), lastB);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    sampleValid = 1'b0;
    repeat (2) begin
      @(posedge clk);
      edgeIdx++;
    end
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) hist[k] = 0;
    lastAcc = -100;
    dueEdge = -1;
    lastA = 0;
    lastB = 0;
    chk("R8 reset valid A", int'(validA), 0);
    chk("R8 reset valid B", int'(validB), 0);
    chk("R8 reset result A", int'(resultA), 0);
    chk("R8 reset result B", int'(resultB), 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'h00C0FFEE);
    @(negedge clk);
    doReset();

    // R3: impulses with gaps; each window must start from zero
    step(1'b1, 8'd200, "R3");
    idle(12, "R3");
    step(1'b1, 8'd1, "R3");
    idle(10, "R3");
    step(1'b1, 8'd0, "R3");
    idle(9, "R3");

    // R5 / R6: valid held high, junk offered in busy cycles
    for (int i = 0; i < 96; i++) begin
      if (readyNext()) step(1'b1, 8'(8'd17 + 8'(i)), "R5");
      else             step(1'b1, 8'hA5, "R6");
    end
    idle(10, "R6");

    // R1: all-255 stream reaches the 19-bit peak on the all-255 instance
    for (int i = 0; i < 96; i++) begin
      if (readyNext()) step(1'b1, 8'hFF, "R1");
      else             step(1'b0, 8'h00, "R1");
    end
    idle(10, "R1");
    chk("R1 peak B", int'(resultB), 520200);

    // R2: random traffic against the convolution model
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 3) == 0;
      step(v, 8'($urandom), "R2");
    end
    idle(10, "R2");

    // R8: reset mid-window clears history and drops the pending output
    step(1'b1, 8'd77, "R8");
    idle(3, "R8");
    doReset();
    idle(10, "R8");
    step(1'b1, 8'd5, "R8");
    idle(9, "R8");
    chk("R8 fresh history A", int'(resultA), int'(COEF_A[7:0]) * 5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule